// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This block lets a host processor reach a bank of 28 byte-wide codec control registers through just two bus words. The host writes a command word that carries a register index, a data byte and a write-request flag. It polls that same flag, which stays high as a busy indication until the internal write has finished. Results are read from a second word, which holds the byte of the most recently addressed register and a live interrupt-request bit.

The register bank has three kinds of slot. Index 0 is a status byte that follows an input from the analog side and cannot be written. Index 11 holds event flags: the analog side sets them, and the host clears them by writing ones. All other slots are plain read/write bytes that come out of reset with fixed values. Every accepted write to a writable slot is also passed to the analog side as a one-cycle strobe that carries the index and the byte.

Read data has a deliberate latency. After a command changes the register index, the byte in the data word keeps its previous value for a fixed number of cycles and then takes the value of the new register. Host software is expected to wait out this window before it samples the data word.

Top module: `codec_reg_bridge`

## Requirements
- R1: Every bus request sampled with `bus_sel` high is answered by `bus_ack` high in the next cycle only; `bus_ack` is low in a cycle that follows a cycle without a request.
- R2: A read of word 0 (`bus_wsel`=0) returns the busy flag in bit 16, the current register index in bits 14:8 and the current data byte in bits 7:0, with all other bits zero; after reset it reads 0x00000000.
- R3: A word-0 write with bit 16 set, accepted while idle, makes bit 16 read as 1 in exactly the next 4 cycles. The register is then updated and bit 16 reads 0.
- R4: A word-0 write that arrives while busy is ignored: the index, the data byte and the pending write are all unchanged, and the target of the ignored command keeps its value.
- R5: A completed write to an index from 1 to 27 raises `acod_wr_stb` for exactly one cycle, with `acod_wr_addr` and `acod_wr_data` equal to the command's index and byte.
- R6: After any accepted word-0 command, bits 7:0 of word 1 hold their previous value for 6 cycles and then show the register selected by the command's index.
- R7: Reset values for indices 0..27 are, in index order: 00 FC 1B 20 00 80 00 00 FF 1F 3F 00 06 06 06 06 00 00 00 00 00 34 07 44 1F 00 00 00 (hex).
- R8: Index 0 reads the `stat_in` byte, and writes to it neither change it nor raise the strobe.
- R9: Index 11 bits are set by `flag_set` pulses, and a host write clears exactly the bits written as 1. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: Indices 28 to 127 read as 0x00, and writes to them raise no strobe.
- R11: Bit 8 of word 1 is 1 exactly when some bit n in 0..5 is set in index 11 while bit n of index 10 is 0, where a 1 in index 10 masks the source. Bits 31:9 of word 1 are zero.
- R12: Writes to word 1 have no effect on the command word, the busy flag or the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host request valid for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wsel | input | 1 | Word select: 0 = command word (offset 0x00), 1 = data word (offset 0x04) |
| bus_wdata | input | 32 | Host write data |
| bus_ack | output | 1 | Request acknowledge, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| stat_in | input | 8 | Status byte shown at index 0 |
| flag_set | input | 8 | Per-bit set pulses for index 11 |
| acod_wr_stb | output | 1 | One-cycle register write strobe toward the analog side |
| acod_wr_addr | output | 7 | Index of the strobed write |
| acod_wr_data | output | 8 | Byte of the strobed write |

## Verification
The assertions check the properties that hold on every cycle. The acknowledge follows each request by exactly one cycle. The command fields stay frozen while a write is in flight, and busy drops in the cycle after a commit. The strobe never lasts longer than one cycle and never targets index 0 or an index past the bank. Event flags never clear without a host write to index 11, and the returned byte only moves when the read latency expires. Other behaviours depend on values and sequences, so only the bench scenarios can show them. These are the exact busy count of 4, the six stale reads before fresh data arrives, every reset value, the write-one-to-clear arithmetic with set priority, the masked interrupt bit, and the silent discard of commands sent while busy or written to the data word.

// File: rtl/codec_reg_bridge_pkg.sv
package codec_reg_bridge_pkg;

  localparam int NREG     = 28;
  localparam int REG_AW   = 7;
  localparam int REG_DW   = 8;
  localparam int BUS_DW   = 32;
  localparam int STAT_IDX = 0;
  localparam int MASK_IDX = 10;
  localparam int FLAG_IDX = 11;
  localparam int IRQ_SRC  = 6;

  typedef enum logic [1:0] {
    RK_RW,
    RK_RO,
    RK_W1C
  } reg_kind_e;

  // Power-on content of every slot.
  function automatic logic [REG_DW-1:0] reset_value(input int idx);
    case (idx)
      1:       return 8'hFC;
      2:       return 8'h1B;
      3:       return 8'h20;
      5:       return 8'h80;
      8:       return 8'hFF;
      9:       return 8'h1F;
      10:      return 8'h3F;
      12, 13, 14, 15: return 8'h06;
      21:      return 8'h34;
      22:      return 8'h07;
      23:      return 8'h44;
      24:      return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic reg_kind_e kind_of(input int idx);
    if (idx == STAT_IDX) return RK_RO;
    if (idx == FLAG_IDX) return RK_W1C;
    return RK_RW;
  endfunction

  function automatic logic writable(input logic [REG_AW-1:0] a);
    return (a != '0) && (a < REG_AW'(NREG));
  endfunction

  function automatic logic irq_of(input logic [REG_DW-1:0] flags,
                                  input logic [REG_DW-1:0] mask);
    return |(flags[IRQ_SRC-1:0] & ~mask[IRQ_SRC-1:0]);
  endfunction

  function automatic logic [BUS_DW-1:0] pack_cmd(input logic busy,
                                                 input logic [REG_AW-1:0] a,
                                                 input logic [REG_DW-1:0] d);
    return {15'd0, busy, 1'b0, a, d};
  endfunction

  function automatic logic [BUS_DW-1:0] pack_data(input logic irq,
                                                  input logic [REG_DW-1:0] b);
    return {23'd0, irq, b};
  endfunction

endpackage

// File: rtl/codec_cmd_seq.sv
module codec_cmd_seq
  import codec_reg_bridge_pkg::*;
#(
  parameter int WR_CYC = 4,
  parameter int RD_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic              cmd_wr,
  input  logic [REG_AW-1:0] cmd_addr,
  input  logic [REG_DW-1:0] cmd_data,
  output logic              busy,
  output logic [REG_AW-1:0] cur_addr,
  output logic [REG_DW-1:0] cur_data,
  output logic              commit,
  output logic              rd_load
);

  localparam int WCW = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;
  localparam int RCW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;

  logic [WCW-1:0] wcnt;
  logic [RCW-1:0] rcnt;
  logic           rd_pend;
  logic           accept;

  assign accept  = cmd_vld && !busy;
  assign commit  = busy && (wcnt == WCW'(WR_CYC - 1));
  assign rd_load = rd_pend && (rcnt == RCW'(RD_LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      cur_data <= '0;
      wcnt     <= '0;
      rcnt     <= '0;
      rd_pend  <= 1'b0;
    end else if (accept) begin
      cur_addr <= cmd_addr;
      cur_data <= cmd_data;
      busy     <= cmd_wr;
      wcnt     <= '0;
      rcnt     <= '0;
      rd_pend  <= 1'b1;
    end else begin
      if (busy) begin
        if (commit) busy <= 1'b0;
        else        wcnt <= wcnt + 1'b1;
      end
      if (rd_pend) begin
        if (rd_load) rd_pend <= 1'b0;
        else         rcnt    <= rcnt + 1'b1;
      end
    end
  end

  AST_CMD_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> ($stable(cur_addr) && $stable(cur_data))); // R4

  AST_BUSY_ENDS_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy); // R3

  AST_LOAD_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> !rd_load); // R6

endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_reg_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_DW-1:0] stat_in,
  input  logic [REG_DW-1:0] flag_set,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_val,
  output logic              irq
);

  localparam int IW = $clog2(NREG);

  logic [REG_DW-1:0] bank [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
    logic [REG_DW-1:0] q;
    assign bank[gi] = q;

    if (kind_of(gi) == RK_RO) begin : g_ro
      always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_value(gi);
        else        q <= stat_in;
      end
    end else if (kind_of(gi) == RK_W1C) begin : g_w1c
      logic hit;
      assign hit = wr_en && (wr_addr == REG_AW'(gi));
      always_ff @(posedge clk) begin
        if (!rst_n) q <= reset_value(gi);
        else        q <= (q & ~(hit ? wr_data : '0)) | flag_set;
      end

      AST_FLAG_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ((q & $past(q)) == $past(q))); // R9
    end else begin : g_rw
      logic hit;
      assign hit = wr_en && (wr_addr == REG_AW'(gi));
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= reset_value(gi);
        else if (hit) q <= wr_data;
      end
    end
  end

  always_comb begin
    if (rd_addr < REG_AW'(NREG)) rd_val = bank[rd_addr[IW-1:0]];
    else                         rd_val = '0;
  end

  assign irq = irq_of(bank[FLAG_IDX], bank[MASK_IDX]);

endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import codec_reg_bridge_pkg::*;
#(
  parameter int WR_CYC = 4,
  parameter int RD_LAT = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_wsel,
  input  logic [31:0] bus_wdata,
  output logic        bus_ack,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  stat_in,
  input  logic [7:0]  flag_set,
  output logic        acod_wr_stb,
  output logic [6:0]  acod_wr_addr,
  output logic [7:0]  acod_wr_data
);

  logic              cmd_vld;
  logic              busy;
  logic              commit;
  logic              rd_load;
  logic [REG_AW-1:0] cur_addr;
  logic [REG_DW-1:0] cur_data;
  logic [REG_DW-1:0] rd_val;
  logic [REG_DW-1:0] rd_byte;
  logic              irq;
  logic              unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:17], bus_wdata[15]};

  assign cmd_vld = bus_sel && bus_wr && !bus_wsel;

  codec_cmd_seq #(
    .WR_CYC (WR_CYC),
    .RD_LAT (RD_LAT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_vld  (cmd_vld),
    .cmd_wr   (bus_wdata[16]),
    .cmd_addr (bus_wdata[14:8]),
    .cmd_data (bus_wdata[7:0]),
    .busy     (busy),
    .cur_addr (cur_addr),
    .cur_data (cur_data),
    .commit   (commit),
    .rd_load  (rd_load)
  );

  assign acod_wr_stb  = commit && writable(cur_addr);
  assign acod_wr_addr = cur_addr;
  assign acod_wr_data = cur_data;

  codec_reg_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acod_wr_stb),
    .wr_addr  (cur_addr),
    .wr_data  (cur_data),
    .stat_in  (stat_in),
    .flag_set (flag_set),
    .rd_addr  (cur_addr),
    .rd_val   (rd_val),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_byte <= reset_value(STAT_IDX);
    else if (rd_load) rd_byte <= rd_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= bus_sel;
      if (bus_sel && !bus_wr)
        bus_rdata <= bus_wsel ? pack_data(irq, rd_byte)
                              : pack_cmd(busy, cur_addr, cur_data);
      else
        bus_rdata <= '0;
    end
  end

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ack); // R1

  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ack); // R1

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acod_wr_stb |=> !acod_wr_stb); // R5

  AST_STB_ONLY_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    acod_wr_stb |-> (acod_wr_addr != 7'd0 && acod_wr_addr < 7'(NREG))); // R10

  AST_RDBYTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(rd_byte)); // R6

endmodule

// File: tb/sim_codec_reg_bridge.sv
module sim_codec_reg_bridge;

  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 100000;
  localparam int NVEC    = 31;

  // {index[6:0], expected byte[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    15'h0000, 15'h01FC, 15'h021B, 15'h0320, 15'h0400, 15'h0580, 15'h0600,
    15'h0700, 15'h08FF, 15'h091F, 15'h0A3F, 15'h0B00, 15'h0C06, 15'h0D06,
    15'h0E06, 15'h0F06, 15'h1000, 15'h1100, 15'h1200, 15'h1300, 15'h1400,
    15'h1534, 15'h1607, 15'h1744, 15'h181F, 15'h1900, 15'h1A00, 15'h1B00,
    15'h1C00, 15'h6400, 15'h7F00
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, bus_wsel;
  logic [31:0] bus_wdata;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [7:0]  stat_in, flag_set;
  logic        acod_wr_stb;
  logic [6:0]  acod_wr_addr;
  logic [7:0]  acod_wr_data;

  int n_chk = 0;
  int n_fail = 0;
  int stb_n = 0;
  logic [6:0] stb_addr;
  logic [7:0] stb_data;
  logic       last_ack;

  always #(CLK_PER / 2) clk = ~clk;

  codec_reg_bridge u0 (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_wsel, .bus_wdata, .bus_ack,
    .bus_rdata, .stat_in, .flag_set, .acod_wr_stb, .acod_wr_addr,
    .acod_wr_data
  );

  always @(negedge clk) begin
    if (acod_wr_stb) begin
      stb_n    <= stb_n + 1;
      stb_addr <= acod_wr_addr;
      stb_data <= acod_wr_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic bus_write(input logic ws, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wsel = ws; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic ws, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_wsel = ws;
    @(negedge clk);
    bus_sel  = 1'b0;
    last_ack = bus_ack;
    d        = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] sel_cmd(input logic [6:0] a);
    return {17'd0, a, 8'h00};
  endfunction

  function automatic logic [31:0] wr_cmd(input logic [6:0] a, input logic [7:0] d);
    return 32'h0001_0000 | {17'd0, a, d};
  endfunction

  task automatic read_reg(input logic [6:0] a, output logic [31:0] d);
    bus_write(1'b0, sel_cmd(a));
    idle(7);
    bus_read(1'b1, d);
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] v);
    bus_write(1'b0, wr_cmd(a, v));
    idle(8);
  endtask

  bit done = 0;

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int s0, busy_reads;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wsel = 1'b0;
    bus_wdata = '0; stat_in = 8'h00; flag_set = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 ack idle after reset", {31'd0, bus_ack}, 32'd0);
    check("R5 no strobe after reset", {31'd0, acod_wr_stb}, 32'd0);
    bus_read(1'b0, rd);
    check("R2 command word reset", rd, 32'h0);
    check("R1 ack on read", {31'd0, last_ack}, 32'd1);
    idle(1);
    check("R1 ack drops", {31'd0, bus_ack}, 32'd0);
    bus_read(1'b1, rd);
    check("R11 data word reset", rd, 32'h0);

    // table walk: reset values and unused range
    for (int i = 0; i < NVEC; i++) begin
      read_reg(VEC[i][14:8], rd);
      check($sformatf("R7/R10 index %0d", VEC[i][14:8]), rd, {24'd0, VEC[i][7:0]});
    end

    // R3 busy window and R5 strobe
    s0 = stb_n;
    bus_write(1'b0, wr_cmd(7'd2, 8'hA5));
    busy_reads = 0;
    for (int k = 0; k < 20; k++) begin
      bus_read(1'b0, rd);
      if (rd[16]) busy_reads++;
      else break;
    end
    check("R3 busy cycles", busy_reads, 4);
    check("R2 command word after write", rd, 32'h0000_02A5);
    idle(2);
    check("R5 strobe count", stb_n - s0, 1);
    check("R5 strobe addr/data", {stb_addr, stb_data}, {7'd2, 8'hA5});
    idle(10);

    // R6 read latency: 6 stale reads then fresh data
    bus_write(1'b0, sel_cmd(7'd1));
    for (int k = 0; k < 6; k++) begin
      bus_read(1'b1, rd);
      check($sformatf("R6 stale read %0d", k), rd, 32'h0000_00A5);
    end
    bus_read(1'b1, rd);
    check("R6 fresh read", rd, 32'h0000_00FC);

    // R4 commands while busy are dropped
    s0 = stb_n;
    bus_write(1'b0, wr_cmd(7'd3, 8'h11));
    bus_write(1'b0, wr_cmd(7'd4, 8'h22));
    bus_write(1'b0, sel_cmd(7'd5));
    idle(10);
    bus_read(1'b0, rd);
    check("R4 command word kept", rd, 32'h0000_0311);
    check("R4 single strobe", stb_n - s0, 1);

    // R12 data word writes ignored
    bus_write(1'b1, 32'h0001_7F66);
    bus_read(1'b0, rd);
    check("R12 command word unchanged", rd, 32'h0000_0311);
    idle(6);
    check("R12 no strobe", stb_n - s0, 1);
    read_reg(7'd4, rd);
    check("R4 dropped target unchanged", rd, 32'h0);
    read_reg(7'd3, rd);
    check("R4 accepted write landed", rd, 32'h11);

    // R8 status slot
    stat_in = 8'h3C;
    s0 = stb_n;
    write_reg(7'd0, 8'h55);
    check("R8 no strobe", stb_n - s0, 0);
    read_reg(7'd0, rd);
    check("R8 status value", rd, 32'h3C);

    // R10 out-of-range write
    write_reg(7'd50, 8'h77);
    check("R10 no strobe", stb_n - s0, 0);
    bus_read(1'b1, rd);
    check("R10 reads zero", rd, 32'h0);

    // R9 flags
    flag_set = 8'h0C;
    @(negedge clk);
    flag_set = 8'h00;
    read_reg(7'd11, rd);
    check("R9/R11 flags set, masked irq", rd, 32'h0000_000C);
    write_reg(7'd11, 8'h04);
    bus_read(1'b1, rd);
    check("R9 write one clears", rd, 32'h08);
    flag_set = 8'h08;
    write_reg(7'd11, 8'h08);
    flag_set = 8'h00;
    bus_read(1'b1, rd);
    check("R9 set wins over clear", rd, 32'h08);

    // R11 interrupt bit
    write_reg(7'd10, 8'h37);
    bus_read(1'b1, rd);
    check("R11 unmasked irq", rd, 32'h0000_0137);
    write_reg(7'd11, 8'h08);
    bus_read(1'b1, rd);
    check("R11 irq after clear", rd, 32'h0);
    flag_set = 8'h40;
    @(negedge clk);
    flag_set = 8'h00;
    read_reg(7'd11, rd);
    check("R11 bit 6 not a source", rd, 32'h0000_0040);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule